// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit carries out the atomic store-class instructions of a packet-filter virtual machine. The decode stage hands it the raw 8-bit load/store opcode, the 32-bit immediate, the base register value, a signed 16-bit displacement, the source register value and the current value of R0. The unit checks that the instruction is a legal atomic, then performs one locked read followed by one locked write on a synchronous memory port. It returns the values that the register file must write back.

The operation is chosen by the immediate, not by the opcode. Four arithmetic/logic updates (add, and, or, xor) combine the memory value with the source operand. Each of them may optionally return the pre-update memory value into the source register. Exchange swaps the source register and memory. Compare-exchange compares memory with R0, stores the source value only when the two are equal, and always hands the old memory value back through R0.

The memory port returns read data one cycle after a read request. The lock output stays high from the read cycle through the write cycle, so an external arbiter can keep other masters out.

Top module: `amo_unit`

## Requirements
- R1: An opcode is accepted only when bits 7:5 are 3'b110 (atomic mode), bits 2:0 are 3'b011 (register-store class), and bits 4:3 are 2'b00 (32-bit word) or 2'b11 (64-bit double word). Any other opcode sets `illegal` with `done` one cycle after `start`, with no memory request and no register write-back.
- R2: The memory address is the low AW bits of `base` plus the sign-extended 16-bit `offset`. The read and the write of one operation use the same address.
- R3: A legal operation issues a read (`mem_req`=1, `mem_we`=0) in the first cycle after `start` and a write in the second cycle. `mem_lock` is high in both cycles. `done` pulses for one cycle in the third cycle after `start`.
- R4: Immediates 0x00, 0x50, 0x40 and 0xa0 store (old + src), (old & src), (old | src) and (old ^ src) respectively, and leave the registers unwritten.
- R5: Setting bit 0 of those four immediates (0x01, 0x51, 0x41, 0xa1) also returns the old memory value on `src_wdata` with `src_we`.
- R6: Immediate 0xe1 stores `src_in` and returns the old memory value to the source register.
- R7: Immediate 0xf1 compares memory with `r0_in`. It writes `src_in` only on equality; on a mismatch the write cycle has no request but keeps `mem_lock` high. In both cases `r0_we` is set and `r0_wdata` is the old value, zero-extended. The source register is not written.
- R8: For 32-bit operations only bits 31:0 of the operands take part. Returned values are zero-extended, `mem_dw` is low, and bits 63:32 of `mem_wdata` are zero.
- R9: Any immediate outside the ten listed codes, including any code with bits above bit 7 set, is illegal and behaves as in R1.
- R10: A `start` that arrives while `busy` is high is ignored and does not change the running operation.
- R11: After reset the unit is idle: `busy`, `done`, `mem_req` and `mem_lock` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| opcode | input | 8 | Load/store opcode of the instruction |
| imm | input | 32 | Immediate that selects the atomic operation |
| base | input | 64 | Destination (address base) register value |
| offset | input | 16 | Signed displacement |
| src_in | input | 64 | Source register value |
| r0_in | input | 64 | R0 value (comparand for compare-exchange) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Valid with done: instruction rejected |
| src_we | output | 1 | Valid with done: write source register |
| src_wdata | output | 64 | Value for the source register |
| r0_we | output | 1 | Valid with done: write R0 |
| r0_wdata | output | 64 | Value for R0 |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_dw | output | 1 | Access is 64-bit (else 32-bit) |
| mem_lock | output | 1 | Hold the port for the whole read-modify-write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid the cycle after a read request |

## Verification
Several properties are checked on every cycle. Every request carries the lock. A write always follows a read in the previous cycle at the same address. A rejected instruction completes with no memory access and no write-back. `done` never lasts two cycles. A 32-bit write never drives the upper data half. The arithmetic results need the scenarios to show them: the values of each immediate code, the fetch and compare outcomes, zero-extension on the returned registers, the exact address and latency, and the dropped `start` while busy.

// File: rtl/amo_pkg.sv
package amo_pkg;

    localparam int DW = 64;

    typedef enum logic [2:0] {
        OP_ADD, OP_AND, OP_OR, OP_XOR, OP_XCHG, OP_CMPX
    } amo_op_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_RD, ST_WR, ST_DONE
    } amo_state_e;

    localparam logic [2:0] MODE_ATOMIC = 3'b110;
    localparam logic [2:0] CLASS_STX   = 3'b011;
    localparam logic [1:0] SZ_WORD     = 2'b00;
    localparam logic [1:0] SZ_DWORD    = 2'b11;

    typedef struct packed {
        logic    legal;
        amo_op_e op;
        logic    fetch;
        logic    dw;
    } amo_dec_t;

    typedef struct packed {
        logic [DW-1:0] mem_new;
        logic          mem_wr;
        logic          src_we;
        logic [DW-1:0] src_val;
        logic          r0_we;
        logic [DW-1:0] r0_val;
    } amo_res_t;

    function automatic logic [DW-1:0] size_mask(input logic dw);
        return dw ? {DW{1'b1}} : {{(DW/2){1'b0}}, {(DW/2){1'b1}}};
    endfunction

endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
(
    input  logic [7:0]  opcode,
    input  logic [31:0] imm,
    output amo_dec_t    dec
);
    logic opc_ok;
    logic imm_ok;

    assign opc_ok = (opcode[7:5] == MODE_ATOMIC) && (opcode[2:0] == CLASS_STX) &&
                    ((opcode[4:3] == SZ_WORD) || (opcode[4:3] == SZ_DWORD));

    always_comb begin
        imm_ok = 1'b1;
        dec.op = OP_ADD;
        unique case (imm)
            32'h00, 32'h01: dec.op = OP_ADD;
            32'h50, 32'h51: dec.op = OP_AND;
            32'h40, 32'h41: dec.op = OP_OR;
            32'ha0, 32'ha1: dec.op = OP_XOR;
            32'he1:         dec.op = OP_XCHG;
            32'hf1:         dec.op = OP_CMPX;
            default:        imm_ok = 1'b0;
        endcase
        dec.fetch = imm[0];
        dec.dw    = (opcode[4:3] == SZ_DWORD);
        dec.legal = opc_ok && imm_ok;
    end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
(
    input  amo_dec_t      dec,
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] src_val,
    input  logic [DW-1:0] r0_val,
    output amo_res_t      res
);
    logic [DW-1:0] m, o, s, r, nv;
    logic          is_arith;

    assign m = size_mask(dec.dw);
    assign o = old_val & m;
    assign s = src_val & m;
    assign r = r0_val & m;
    assign is_arith = (dec.op == OP_ADD) || (dec.op == OP_AND) ||
                      (dec.op == OP_OR)  || (dec.op == OP_XOR);

    always_comb begin
        unique case (dec.op)
            OP_ADD:  nv = o + s;
            OP_AND:  nv = o & s;
            OP_OR:   nv = o | s;
            OP_XOR:  nv = o ^ s;
            default: nv = s;
        endcase
        res.mem_new = nv & m;
        res.mem_wr  = (dec.op != OP_CMPX) || (o == r);
        res.src_we  = (is_arith && dec.fetch) || (dec.op == OP_XCHG);
        res.src_val = o;
        res.r0_we   = (dec.op == OP_CMPX);
        res.r0_val  = o;
    end
endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
    import amo_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  amo_dec_t      dec_in,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] src_in,
    input  logic [DW-1:0] r0_in,
    input  amo_res_t      res,
    output amo_dec_t      dec_q,
    output logic [DW-1:0] src_q,
    output logic [DW-1:0] r0_q,
    output logic          busy,
    output logic          done,
    output logic          illegal,
    output logic          src_we,
    output logic [DW-1:0] src_wdata,
    output logic          r0_we,
    output logic [DW-1:0] r0_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_dw,
    output logic          mem_lock,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    amo_state_e    state;
    logic [AW-1:0] addr_q;
    logic          ill_q, swe_q, rwe_q;
    logic [DW-1:0] sval_q, rval_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            dec_q  <= '0;
            addr_q <= '0;
            src_q  <= '0;
            r0_q   <= '0;
            ill_q  <= 1'b0;
            swe_q  <= 1'b0;
            rwe_q  <= 1'b0;
            sval_q <= '0;
            rval_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    dec_q  <= dec_in;
                    addr_q <= addr_in;
                    src_q  <= src_in;
                    r0_q   <= r0_in;
                    ill_q  <= !dec_in.legal;
                    swe_q  <= 1'b0;
                    rwe_q  <= 1'b0;
                    state  <= dec_in.legal ? ST_RD : ST_DONE;
                end
                ST_RD: state <= ST_WR;
                ST_WR: begin
                    swe_q  <= res.src_we;
                    sval_q <= res.src_val;
                    rwe_q  <= res.r0_we;
                    rval_q <= res.r0_val;
                    state  <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_DONE);
    assign illegal   = done && ill_q;
    assign src_we    = done && swe_q;
    assign src_wdata = sval_q;
    assign r0_we     = done && rwe_q;
    assign r0_wdata  = rval_q;
    assign mem_lock  = (state == ST_RD) || (state == ST_WR);
    assign mem_req   = (state == ST_RD) || ((state == ST_WR) && res.mem_wr);
    assign mem_we    = (state == ST_WR);
    assign mem_dw    = dec_q.dw;
    assign mem_addr  = addr_q;
    assign mem_wdata = res.mem_new;
endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [7:0]    opcode,
    input  logic [31:0]   imm,
    input  logic [63:0]   base,
    input  logic [15:0]   offset,
    input  logic [63:0]   src_in,
    input  logic [63:0]   r0_in,
    output logic          busy,
    output logic          done,
    output logic          illegal,
    output logic          src_we,
    output logic [63:0]   src_wdata,
    output logic          r0_we,
    output logic [63:0]   r0_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_dw,
    output logic          mem_lock,
    output logic [AW-1:0] mem_addr,
    output logic [63:0]   mem_wdata,
    input  logic [63:0]   mem_rdata
);
    localparam int EXT = AW - 16;

    amo_dec_t      dec_in, dec_q;
    amo_res_t      res;
    logic [AW-1:0] eff_addr;
    logic [DW-1:0] src_q, r0_q;

    assign eff_addr = base[AW-1:0] + {{EXT{offset[15]}}, offset};

    amo_decode u_dec (
        .opcode (opcode),
        .imm    (imm),
        .dec    (dec_in)
    );

    amo_alu u_alu (
        .dec     (dec_q),
        .old_val (mem_rdata),
        .src_val (src_q),
        .r0_val  (r0_q),
        .res     (res)
    );

    amo_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .dec_in    (dec_in),
        .addr_in   (eff_addr),
        .src_in    (src_in),
        .r0_in     (r0_in),
        .res       (res),
        .dec_q     (dec_q),
        .src_q     (src_q),
        .r0_q      (r0_q),
        .busy      (busy),
        .done      (done),
        .illegal   (illegal),
        .src_we    (src_we),
        .src_wdata (src_wdata),
        .r0_we     (r0_we),
        .r0_wdata  (r0_wdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_dw    (mem_dw),
        .mem_lock  (mem_lock),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          done,
    input logic          illegal,
    input logic          src_we,
    input logic          r0_we,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_dw,
    input logic          mem_lock,
    input logic [AW-1:0] mem_addr,
    input logic [63:0]   mem_wdata
);
    // R3
    lock_on_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_lock);

    // R3
    write_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> $past(mem_req && !mem_we));

    // R2
    same_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_addr == $past(mem_addr)));

    // R1
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (done && illegal) |-> (!src_we && !r0_we && !mem_req && !mem_lock));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    word_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !mem_dw) |-> (mem_wdata[63:32] == 32'h0));
endmodule

bind amo_unit amo_unit_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .done      (done),
    .illegal   (illegal),
    .src_we    (src_we),
    .r0_we     (r0_we),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_dw    (mem_dw),
    .mem_lock  (mem_lock),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/amo_unit_test.sv
module amo_unit_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [7:0]    opcode;
    logic [31:0]   imm;
    logic [63:0]   base, src_in, r0_in;
    logic [15:0]   offset;
    logic          busy, done, illegal, src_we, r0_we;
    logic [63:0]   src_wdata, r0_wdata;
    logic          mem_req, mem_we, mem_dw, mem_lock;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_wdata;
    logic [63:0]   mem_rdata;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    amo_unit #(.AW(AW)) uut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .imm(imm),
        .base(base), .offset(offset), .src_in(src_in), .r0_in(r0_in),
        .busy(busy), .done(done), .illegal(illegal), .src_we(src_we),
        .src_wdata(src_wdata), .r0_we(r0_we), .r0_wdata(r0_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_dw(mem_dw), .mem_lock(mem_lock),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model: 16 double words, one-cycle read latency
    logic [63:0] mem [16];
    logic        pre_we;
    logic [3:0]  pre_idx;
    logic [63:0] pre_val;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (pre_we) mem[pre_idx] <= pre_val;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[6:3]];
        if (mem_req && mem_we) begin
            if (mem_dw) mem[mem_addr[6:3]] <= mem_wdata;
            else        mem[mem_addr[6:3]][31:0] <= mem_wdata[31:0];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic preload(input logic [3:0] idx, input logic [63:0] val);
        @(negedge clk);
        pre_we = 1'b1; pre_idx = idx; pre_val = val;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic issue(input logic [7:0] opc, input logic [31:0] im,
                         input logic [63:0] b, input logic [15:0] off,
                         input logic [63:0] s, input logic [63:0] r);
        opcode = opc; imm = im; base = b; offset = off; src_in = s; r0_in = r;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    typedef struct packed {
        logic [3:0]  req;
        logic [7:0]  opc;
        logic [31:0] imm;
        logic [63:0] src;
        logic [63:0] r0;
        logic [63:0] init;
        logic        ill;
        logic [63:0] emem;
        logic        swe;
        logic [63:0] sval;
        logic        rwe;
        logic [63:0] rval;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{4'd4, 8'hdb, 32'h00, 64'h1, 64'h0, 64'h00000001_FFFFFFFF, 1'b0, 64'h00000002_00000000, 1'b0, 64'h0, 1'b0, 64'h0},
        '{4'd5, 8'hdb, 32'h01, 64'h5, 64'h0, 64'hA, 1'b0, 64'hF, 1'b1, 64'hA, 1'b0, 64'h0},
        '{4'd5, 8'hdb, 32'h51, 64'h0FF00FF0_0FF00FF0, 64'h0, 64'hFF00FF00_FF00FF00, 1'b0, 64'h0F000F00_0F000F00, 1'b1, 64'hFF00FF00_FF00FF00, 1'b0, 64'h0},
        '{4'd4, 8'hdb, 32'h40, 64'h0F, 64'h0, 64'hF0, 1'b0, 64'hFF, 1'b0, 64'h0, 1'b0, 64'h0},
        '{4'd8, 8'hc3, 32'ha1, 64'hFFFFFFFF_FFFFFFFF, 64'h0, 64'hAAAAAAAA_12345678, 1'b0, 64'hAAAAAAAA_EDCBA987, 1'b1, 64'h00000000_12345678, 1'b0, 64'h0},
        '{4'd8, 8'hc3, 32'h00, 64'h1, 64'h0, 64'h00000000_FFFFFFFF, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 64'h0},
        '{4'd6, 8'hdb, 32'he1, 64'h2222, 64'h0, 64'h1111, 1'b0, 64'h2222, 1'b1, 64'h1111, 1'b0, 64'h0},
        '{4'd7, 8'hdb, 32'hf1, 64'h99, 64'h55, 64'h55, 1'b0, 64'h99, 1'b0, 64'h0, 1'b1, 64'h55},
        '{4'd7, 8'hdb, 32'hf1, 64'h99, 64'h56, 64'h55, 1'b0, 64'h55, 1'b0, 64'h0, 1'b1, 64'h55},
        '{4'd7, 8'hc3, 32'hf1, 64'h12345678_00000088, 64'hFFFFFFFF_00000077, 64'hDEAD0000_00000077, 1'b0, 64'hDEAD0000_00000088, 1'b0, 64'h0, 1'b1, 64'h77},
        '{4'd1, 8'hd3, 32'h00, 64'h1, 64'h0, 64'h42, 1'b1, 64'h42, 1'b0, 64'h0, 1'b0, 64'h0},
        '{4'd9, 8'hdb, 32'h02, 64'h1, 64'h0, 64'h42, 1'b1, 64'h42, 1'b0, 64'h0, 1'b0, 64'h0},
        '{4'd1, 8'h7b, 32'h00, 64'h1, 64'h0, 64'h42, 1'b1, 64'h42, 1'b0, 64'h0, 1'b0, 64'h0},
        '{4'd1, 8'hcb, 32'h00, 64'h1, 64'h0, 64'h42, 1'b1, 64'h42, 1'b0, 64'h0, 1'b0, 64'h0},
        '{4'd1, 8'hda, 32'h00, 64'h1, 64'h0, 64'h42, 1'b1, 64'h42, 1'b0, 64'h0, 1'b0, 64'h0},
        '{4'd9, 8'hdb, 32'h100, 64'h1, 64'h0, 64'h42, 1'b1, 64'h42, 1'b0, 64'h0, 1'b0, 64'h0},
        '{4'd4, 8'hdb, 32'ha0, 64'hF0F0, 64'h0, 64'hFFFF, 1'b0, 64'h0F0F, 1'b0, 64'h0, 1'b0, 64'h0},
        '{4'd4, 8'hdb, 32'h50, 64'h0F0F, 64'h0, 64'h00FF, 1'b0, 64'h000F, 1'b0, 64'h0, 1'b0, 64'h0}
    };

    function automatic string rname(input logic [3:0] n);
        case (n)
            4'd1: return "R1";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic wait_done(output int n);
        n = 1;
        while (!done && n < 10) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 50000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
            summary();
        end
    end

    initial begin
        int n;
        string tg;
        rst = 1'b1; start = 1'b0; pre_we = 1'b0; pre_idx = '0; pre_val = '0;
        opcode = '0; imm = '0; base = '0; offset = '0; src_in = '0; r0_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check(!busy && !done && !mem_req && !mem_lock, "R11", "idle after reset",
              {busy, done, mem_req, mem_lock}, 64'h0);

        // table walk: base 0x100 + 0x10 -> address 0x110, memory slot 2
        for (int i = 0; i < NV; i++) begin
            tg = rname(VEC[i].req);
            preload(4'd2, VEC[i].init);
            issue(VEC[i].opc, VEC[i].imm, 64'h100, 16'h0010, VEC[i].src, VEC[i].r0);
            wait_done(n);
            check(n == (VEC[i].ill ? 1 : 3), VEC[i].ill ? tg : "R3", "latency",
                  n, VEC[i].ill ? 1 : 3);
            check(illegal == VEC[i].ill, tg, "illegal flag", illegal, VEC[i].ill);
            check(src_we == VEC[i].swe && (!VEC[i].swe || src_wdata == VEC[i].sval),
                  tg, "source write-back", src_wdata, VEC[i].sval);
            check(r0_we == VEC[i].rwe && (!VEC[i].rwe || r0_wdata == VEC[i].rval),
                  tg, "R0 write-back", r0_wdata, VEC[i].rval);
            @(negedge clk);
            check(mem[2] == VEC[i].emem, tg, "memory", mem[2], VEC[i].emem);
        end

        // R2 / R3: negative offset, address and lock in read and write cycles
        preload(4'd15, 64'h7);
        issue(8'hdb, 32'h00, 64'h2000, 16'hFFF8, 64'h3, 64'h0);
        check(mem_req && !mem_we && mem_lock && mem_addr == 32'h1FF8, "R2",
              "read cycle address", mem_addr, 64'h1FF8);
        @(negedge clk);
        check(mem_req && mem_we && mem_lock && mem_addr == 32'h1FF8, "R3",
              "write cycle", {mem_req, mem_we, mem_lock}, 64'h7);
        @(negedge clk);
        check(done, "R3", "done pulse", done, 1);
        @(negedge clk);
        check(mem[15] == 64'hA && !done, "R3", "result and single pulse", mem[15], 64'hA);

        // R7 mismatch: write cycle has no request but keeps the lock
        preload(4'd2, 64'h10);
        issue(8'hdb, 32'hf1, 64'h100, 16'h0010, 64'h20, 64'h11);
        @(negedge clk);
        check(!mem_req && mem_lock, "R7", "mismatch write cycle",
              {mem_req, mem_lock}, 64'h1);
        wait_done(n);
        @(negedge clk);

        // R8 word write keeps upper data half zero
        preload(4'd2, 64'hFFFFFFFF_00000001);
        issue(8'hc3, 32'h00, 64'h100, 16'h0010, 64'hFFFFFFFF_00000002, 64'h0);
        @(negedge clk);
        check(mem_we && !mem_dw && mem_wdata == 64'h3, "R8", "word write data",
              mem_wdata, 64'h3);
        wait_done(n);
        @(negedge clk);

        // R10 start while busy is dropped
        preload(4'd2, 64'hAB);
        issue(8'hdb, 32'he1, 64'h100, 16'h0010, 64'hCD, 64'h0);
        opcode = 8'hdb; imm = 32'h01; src_in = 64'h5555; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(n);
        check(src_we && src_wdata == 64'hAB && !illegal, "R10", "first op kept",
              src_wdata, 64'hAB);
        @(negedge clk);
        check(mem[2] == 64'hCD, "R10", "memory from first op", mem[2], 64'hCD);
        repeat (2) begin
            check(!mem_req && !done && !busy, "R10", "no second op",
                  {mem_req, done, busy}, 64'h0);
            @(negedge clk);
        end

        summary();
    end
endmodule